// File: doc/BRIEF.md
# DDR3 Command Legality Checker

This block sits beside a DDR3-style command bus and samples the chip select, the row strobe, the column strobe, the write enable, the bank select and sixteen address bits on every rising clock edge. It decodes each sample into a command type and, for column accesses, works out the burst length and whether auto precharge was requested. It keeps an open/closed record for each of eight banks, a tracker for a read burst in flight and a busy window for ZQ calibration. A command that breaks one of the rules below is reported with a reason code, and it does not change any tracked state.

All outputs are registered. They describe the command sampled at the previous rising edge, and `bank_open` shows the bank state after that edge. The ZQ busy lengths and the delay between the end of a burst and the automatic row close are configuration inputs. The caller holds them steady during operation.

Top module: `ddr3_cmd_guard`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `cmd_kind` is 0, `burst_bc4`, `auto_pre` and `err_valid` are 0, `err_code` is 0 and `bank_open` is all zeros.
- R2: Each command sampled with {cs_n,ras_n,cas_n,we_n} is reported on `cmd_kind` one cycle later. The pin patterns map as follows: cs_n=1 gives 0 (deselect). 0111 gives 1 (no-op). 0011 gives 2 (activate). 0101 gives 3 (read). 0100 gives 4 (write). 0010 gives 5 (precharge). 0110 with A10=1 gives 6 (long ZQ) and with A10=0 gives 7 (short ZQ). Every other pattern gives 8 (other).
- R3: For a read or write, `burst_bc4`=1 means a 4-beat chop and 0 means an 8-beat burst. When `cfg_otf_en`=1, `burst_bc4` is the inverse of A12. When `cfg_otf_en`=0, it equals `cfg_fixed_bc4`. For every other command it is 0.
- R4: `auto_pre` equals A10 for a read or write and is 0 otherwise. A legal access with A10=1 closes its bank at the edge BL/2 + `cfg_ap_delay` edges after the access, where BL/2 is 4 for an 8-beat burst and 2 for a chop. A later legal auto-precharge access to the same bank restarts this count.
- R5: A legal activate sets the bit of its bank in `bank_open`. An activate to a bank that is already open is flagged with code 1.
- R6: A read or write to a bank whose `bank_open` bit is 0 is flagged with code 2.
- R7: After a legal read, any read or write in the next BL/2-1 cycles is flagged with code 3. A read or write at cycle BL/2 after the read is accepted. Writes do not start such a window.
- R8: A legal long ZQ makes the next N cycles busy. N is `cfg_zq_init` for the first accepted long ZQ after reset and `cfg_zq_oper` for every later one. A legal short ZQ makes the next `cfg_zq_short` cycles busy. During a busy cycle, any command other than a deselect or no-op is flagged with code 4.
- R9: A legal precharge clears the bank bit, or all bits when A10=1. A precharge to a closed bank is legal.
- R10: A deselect or no-op is never flagged and changes no bank state. Read-burst, ZQ and auto-precharge countdowns keep running through them.
- R11: A flagged command changes no bank, burst or ZQ state. When several rules apply, one code is reported, in this order: 4 first, then 3, then 2 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, low active |
| ras_n | input | 1 | Row strobe, low active |
| cas_n | input | 1 | Column strobe, low active |
| we_n | input | 1 | Write enable, low active |
| ba | input | 3 | Bank select |
| addr | input | 16 | Address bits; A10 and A12 are decoded |
| cfg_otf_en | input | 1 | Take burst length from A12 per command |
| cfg_fixed_bc4 | input | 1 | Chop setting used when per-command selection is off |
| cfg_zq_init | input | 12 | Busy cycles for the first long ZQ |
| cfg_zq_oper | input | 12 | Busy cycles for later long ZQs |
| cfg_zq_short | input | 12 | Busy cycles for a short ZQ |
| cfg_ap_delay | input | 4 | Cycles from burst end to automatic close |
| cmd_kind | output | 4 | Decoded command of the previous sample |
| burst_bc4 | output | 1 | 4-beat chop selected |
| auto_pre | output | 1 | Auto precharge requested |
| err_valid | output | 1 | Previous command broke a rule |
| err_code | output | 3 | Reason: 1 open bank, 2 closed bank, 3 read burst, 4 ZQ busy |
| bank_open | output | 8 | Open flag per bank |

## Verification
A directed opening sequence runs through the cases one after another: the init and runtime ZQ windows, activates to open and closed banks, back-to-back reads at the burst boundary in both burst modes, auto-precharge closes and an all-bank precharge. This separates off-by-one window edges from wrong rule priority. A long random phase follows. It biases commands toward a few banks and mixes in deselects, refresh-like codes and changes of the burst mode, so that overlapping countdowns, reloads and flagged commands meet each other. A reference model in the bench compares every output on every cycle, so a mismatch in any field is tied to the cycle where it first appears.

// File: rtl/ddr3_guard_pkg.sv
package ddr3_guard_pkg;

    typedef enum logic [3:0] {
        CMD_DES   = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_ACT   = 4'd2,
        CMD_RD    = 4'd3,
        CMD_WR    = 4'd4,
        CMD_PRE   = 4'd5,
        CMD_ZQL   = 4'd6,
        CMD_ZQS   = 4'd7,
        CMD_OTHER = 4'd8
    } cmd_kind_e;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_ACT_OPEN = 3'd1,
        ERR_NO_ROW   = 3'd2,
        ERR_BURST    = 3'd3,
        ERR_ZQ_BUSY  = 3'd4
    } err_e;

    localparam int AP_BIT     = 10;
    localparam int CHOP_BIT   = 12;
    localparam int BL8_BEATS  = 8;
    localparam int BC4_BEATS  = 4;
    localparam int BL8_CLKS   = BL8_BEATS / 2;
    localparam int BC4_CLKS   = BC4_BEATS / 2;
    localparam int BURST_W    = $clog2(BL8_CLKS + 1);

    function automatic cmd_kind_e decode_pins(input logic cs_n, input logic ras_n,
                                              input logic cas_n, input logic we_n,
                                              input logic a10);
        cmd_kind_e k;
        if (cs_n) begin
            k = CMD_DES;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  k = CMD_NOP;
                3'b011:  k = CMD_ACT;
                3'b101:  k = CMD_RD;
                3'b100:  k = CMD_WR;
                3'b010:  k = CMD_PRE;
                3'b110:  k = a10 ? CMD_ZQL : CMD_ZQS;
                default: k = CMD_OTHER;
            endcase
        end
        return k;
    endfunction

    function automatic logic is_access(input cmd_kind_e k);
        return (k == CMD_RD) || (k == CMD_WR);
    endfunction

    function automatic logic is_idle(input cmd_kind_e k);
        return (k == CMD_DES) || (k == CMD_NOP);
    endfunction

endpackage

// File: rtl/ddr3_cmd_decode.sv
module ddr3_cmd_decode
    import ddr3_guard_pkg::*;
(
    input  logic      cs_n,
    input  logic      ras_n,
    input  logic      cas_n,
    input  logic      we_n,
    input  logic      a10,
    input  logic      a12,
    input  logic      otf_en,
    input  logic      fixed_bc4,
    output cmd_kind_e kind,
    output logic      bc4,
    output logic      ap,
    output logic      pre_all,
    output logic [BURST_W-1:0] half_len
);

    logic access;

    always_comb begin
        kind     = decode_pins(cs_n, ras_n, cas_n, we_n, a10);
        access   = is_access(kind);
        bc4      = access && (otf_en ? !a12 : fixed_bc4);
        ap       = access && a10;
        pre_all  = (kind == CMD_PRE) && a10;
        half_len = bc4 ? BURST_W'(BC4_CLKS) : BURST_W'(BL8_CLKS);
    end

endmodule

// File: rtl/ddr3_bank_track.sv
module ddr3_bank_track #(
    parameter int NUM_BANKS = 8,
    parameter int BA_W      = $clog2(NUM_BANKS),
    parameter int LOAD_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 act_ok,
    input  logic                 pre_ok,
    input  logic                 pre_all,
    input  logic                 ap_ok,
    input  logic [BA_W-1:0]      bank,
    input  logic [LOAD_W-1:0]    ap_load,
    output logic [NUM_BANKS-1:0] open_vec
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic              sel;
        logic [LOAD_W-1:0] close_cnt;

        assign sel = (bank == BA_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                open_vec[b] <= 1'b0;
                close_cnt   <= '0;
            end else if (pre_ok && (pre_all || sel)) begin
                open_vec[b] <= 1'b0;
                close_cnt   <= '0;
            end else if (act_ok && sel) begin
                open_vec[b] <= 1'b1;
                close_cnt   <= '0;
            end else if (ap_ok && sel) begin
                close_cnt   <= ap_load;
            end else if (close_cnt == LOAD_W'(1)) begin
                open_vec[b] <= 1'b0;
                close_cnt   <= '0;
            end else if (close_cnt != '0) begin
                close_cnt   <= close_cnt - LOAD_W'(1);
            end
        end
    end

endmodule

// File: rtl/ddr3_burst_track.sv
module ddr3_burst_track
    import ddr3_guard_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_ok,
    input  logic [BURST_W-1:0] half_len,
    output logic               busy
);

    logic [BURST_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
        end else if (rd_ok) begin
            left <= half_len - BURST_W'(1);
        end else if (left != '0) begin
            left <= left - BURST_W'(1);
        end
    end

    assign busy = (left != '0);

endmodule

// File: rtl/ddr3_zq_track.sv
module ddr3_zq_track #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             long_ok,
    input  logic             short_ok,
    input  logic [CNT_W-1:0] len_init,
    input  logic [CNT_W-1:0] len_oper,
    input  logic [CNT_W-1:0] len_short,
    output logic             busy
);

    logic             init_done;
    logic [CNT_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            init_done <= 1'b0;
            left      <= '0;
        end else if (long_ok) begin
            init_done <= 1'b1;
            left      <= init_done ? len_oper : len_init;
        end else if (short_ok) begin
            left      <= len_short;
        end else if (left != '0) begin
            left      <= left - CNT_W'(1);
        end
    end

    assign busy = (left != '0);

endmodule

// File: rtl/ddr3_cmd_guard.sv
module ddr3_cmd_guard
    import ddr3_guard_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BA_W      = $clog2(NUM_BANKS),
    parameter int ADDR_W    = 16,
    parameter int ZQ_W      = 12,
    parameter int APD_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      ba,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 cfg_otf_en,
    input  logic                 cfg_fixed_bc4,
    input  logic [ZQ_W-1:0]      cfg_zq_init,
    input  logic [ZQ_W-1:0]      cfg_zq_oper,
    input  logic [ZQ_W-1:0]      cfg_zq_short,
    input  logic [APD_W-1:0]     cfg_ap_delay,
    output logic [3:0]           cmd_kind,
    output logic                 burst_bc4,
    output logic                 auto_pre,
    output logic                 err_valid,
    output logic [2:0]           err_code,
    output logic [NUM_BANKS-1:0] bank_open
);

    localparam int LOAD_W = ((APD_W > BURST_W) ? APD_W : BURST_W) + 1;

    logic [ADDR_W-1:0]  unused_addr;
    cmd_kind_e          kind;
    logic               bc4, ap, pre_all;
    logic [BURST_W-1:0] half_len;
    logic               zq_busy, rd_busy, bank_hit;
    err_e               err;
    logic               legal;
    logic [LOAD_W-1:0]  ap_load;

    assign unused_addr = addr;

    ddr3_cmd_decode i_decode (
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .a10       (addr[AP_BIT]),
        .a12       (addr[CHOP_BIT]),
        .otf_en    (cfg_otf_en),
        .fixed_bc4 (cfg_fixed_bc4),
        .kind      (kind),
        .bc4       (bc4),
        .ap        (ap),
        .pre_all   (pre_all),
        .half_len  (half_len)
    );

    assign bank_hit = bank_open[ba];

    always_comb begin
        err = ERR_NONE;
        if (!is_idle(kind)) begin
            if (zq_busy)
                err = ERR_ZQ_BUSY;
            else if (is_access(kind) && rd_busy)
                err = ERR_BURST;
            else if (is_access(kind) && !bank_hit)
                err = ERR_NO_ROW;
            else if ((kind == CMD_ACT) && bank_hit)
                err = ERR_ACT_OPEN;
        end
    end

    assign legal   = (err == ERR_NONE);
    assign ap_load = LOAD_W'(half_len) + LOAD_W'(cfg_ap_delay);

    ddr3_bank_track #(
        .NUM_BANKS (NUM_BANKS),
        .BA_W      (BA_W),
        .LOAD_W    (LOAD_W)
    ) i_banks (
        .clk      (clk),
        .rst      (rst),
        .act_ok   (legal && (kind == CMD_ACT)),
        .pre_ok   (legal && (kind == CMD_PRE)),
        .pre_all  (pre_all),
        .ap_ok    (legal && ap),
        .bank     (ba),
        .ap_load  (ap_load),
        .open_vec (bank_open)
    );

    ddr3_burst_track i_burst (
        .clk      (clk),
        .rst      (rst),
        .rd_ok    (legal && (kind == CMD_RD)),
        .half_len (half_len),
        .busy     (rd_busy)
    );

    ddr3_zq_track #(
        .CNT_W (ZQ_W)
    ) i_zq (
        .clk       (clk),
        .rst       (rst),
        .long_ok   (legal && (kind == CMD_ZQL)),
        .short_ok  (legal && (kind == CMD_ZQS)),
        .len_init  (cfg_zq_init),
        .len_oper  (cfg_zq_oper),
        .len_short (cfg_zq_short),
        .busy      (zq_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_kind  <= CMD_DES;
            burst_bc4 <= 1'b0;
            auto_pre  <= 1'b0;
            err_valid <= 1'b0;
            err_code  <= ERR_NONE;
        end else begin
            cmd_kind  <= kind;
            burst_bc4 <= bc4;
            auto_pre  <= ap;
            err_valid <= !legal;
            err_code  <= err;
        end
    end

endmodule

// File: rtl/ddr3_cmd_guard_chk.sv
module ddr3_cmd_guard_chk #(
    parameter int NUM_BANKS = 8,
    parameter int BA_W      = 3,
    parameter int ADDR_W    = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic [BA_W-1:0]      ba,
    input logic [ADDR_W-1:0]    addr,
    input logic [3:0]           cmd_kind,
    input logic                 burst_bc4,
    input logic                 auto_pre,
    input logic                 err_valid,
    input logic [2:0]           err_code,
    input logic [NUM_BANKS-1:0] bank_open
);

    a_r1_reset_clean: assert property (@(posedge clk)
        rst |=> (!err_valid && (bank_open == '0) && (cmd_kind == 4'd0)));

    a_r3_chop_only_access: assert property (@(posedge clk) disable iff (rst)
        burst_bc4 |-> ((cmd_kind == 4'd3) || (cmd_kind == 4'd4)));

    a_r4_ap_only_access: assert property (@(posedge clk) disable iff (rst)
        auto_pre |-> ((cmd_kind == 4'd3) || (cmd_kind == 4'd4)));

    a_r5_act_sets_bank: assert property (@(posedge clk) disable iff (rst)
        ((cmd_kind == 4'd2) && !err_valid) |-> bank_open[$past(ba)]);

    a_r6_no_row_is_access: assert property (@(posedge clk) disable iff (rst)
        (err_code == 3'd2) |-> ((cmd_kind == 4'd3) || (cmd_kind == 4'd4)));

    a_r7_burst_is_access: assert property (@(posedge clk) disable iff (rst)
        (err_code == 3'd3) |-> ((cmd_kind == 4'd3) || (cmd_kind == 4'd4)));

    a_r8_zq_flag_not_idle: assert property (@(posedge clk) disable iff (rst)
        (err_code == 3'd4) |-> ((cmd_kind != 4'd0) && (cmd_kind != 4'd1)));

    a_r9_pre_all_closes: assert property (@(posedge clk) disable iff (rst)
        ((cmd_kind == 4'd5) && !err_valid && $past(addr[10])) |-> (bank_open == '0));

    a_r10_idle_clean: assert property (@(posedge clk) disable iff (rst)
        ((cmd_kind == 4'd0) || (cmd_kind == 4'd1)) |-> !err_valid);

endmodule

bind ddr3_cmd_guard ddr3_cmd_guard_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BA_W      (BA_W),
    .ADDR_W    (ADDR_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .ba        (ba),
    .addr      (addr),
    .cmd_kind  (cmd_kind),
    .burst_bc4 (burst_bc4),
    .auto_pre  (auto_pre),
    .err_valid (err_valid),
    .err_code  (err_code),
    .bank_open (bank_open)
);

// File: tb/test_ddr3_cmd_guard.sv
module test_ddr3_cmd_guard;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [2:0]  ba = '0;
    logic [15:0] addr = '0;
    logic        cfg_otf_en = 1'b1, cfg_fixed_bc4 = 1'b0;
    logic [11:0] cfg_zq_init = 12'd20, cfg_zq_oper = 12'd10, cfg_zq_short = 12'd5;
    logic [3:0]  cfg_ap_delay = 4'd2;
    logic [3:0]  cmd_kind;
    logic        burst_bc4, auto_pre, err_valid;
    logic [2:0]  err_code;
    logic [7:0]  bank_open;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    ddr3_cmd_guard i_ddr3_cmd_guard (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .cfg_otf_en(cfg_otf_en), .cfg_fixed_bc4(cfg_fixed_bc4),
        .cfg_zq_init(cfg_zq_init), .cfg_zq_oper(cfg_zq_oper), .cfg_zq_short(cfg_zq_short),
        .cfg_ap_delay(cfg_ap_delay), .cmd_kind(cmd_kind), .burst_bc4(burst_bc4),
        .auto_pre(auto_pre), .err_valid(err_valid), .err_code(err_code), .bank_open(bank_open)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model state
    int  m_open[8];
    int  m_apc[8];
    int  m_rd = 0, m_zq = 0;
    bit  m_zq_done = 0;
    int  e_kind = 0, e_bc4 = 0, e_ap = 0, e_err = 0, e_prev_err = 0;
    int  e_open = 0;

    function automatic int ref_kind(logic c, logic r, logic a, logic w, logic a10);
        if (c) return 0;
        case ({r, a, w})
            3'b111: return 1;
            3'b011: return 2;
            3'b101: return 3;
            3'b100: return 4;
            3'b010: return 5;
            3'b110: return a10 ? 6 : 7;
            default: return 8;
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            for (int b = 0; b < 8; b++) begin m_open[b] = 0; m_apc[b] = 0; end
            m_rd = 0; m_zq = 0; m_zq_done = 0;
            e_kind = 0; e_bc4 = 0; e_ap = 0; e_err = 0; e_prev_err = 0; e_open = 0;
        end else begin
            int k, bk, bc, ap, er, half;
            k  = ref_kind(cs_n, ras_n, cas_n, we_n, addr[10]);
            bk = ba;
            bc = 0; ap = 0;
            if (k == 3 || k == 4) begin
                bc = cfg_otf_en ? !addr[12] : cfg_fixed_bc4;
                ap = addr[10];
            end
            half = bc ? 2 : 4;
            er = 0;
            if (k > 1) begin
                if (m_zq > 0) er = 4;
                else if ((k == 3 || k == 4) && m_rd > 0) er = 3;
                else if ((k == 3 || k == 4) && m_open[bk] == 0) er = 2;
                else if (k == 2 && m_open[bk] != 0) er = 1;
            end
            if (er == 0 && k == 3) m_rd = half - 1;
            else if (m_rd > 0) m_rd--;
            if (er == 0 && k == 6) begin m_zq = m_zq_done ? cfg_zq_oper : cfg_zq_init; m_zq_done = 1; end
            else if (er == 0 && k == 7) m_zq = cfg_zq_short;
            else if (m_zq > 0) m_zq--;
            for (int b = 0; b < 8; b++) begin
                if (er == 0 && k == 5 && (addr[10] || b == bk)) begin m_open[b] = 0; m_apc[b] = 0; end
                else if (er == 0 && k == 2 && b == bk) begin m_open[b] = 1; m_apc[b] = 0; end
                else if (er == 0 && ap != 0 && b == bk) m_apc[b] = half + cfg_ap_delay;
                else if (m_apc[b] == 1) begin m_open[b] = 0; m_apc[b] = 0; end
                else if (m_apc[b] > 0) m_apc[b]--;
            end
            e_prev_err = e_err;
            e_kind = k; e_bc4 = bc; e_ap = ap; e_err = er;
            e_open = 0;
            for (int b = 0; b < 8; b++) if (m_open[b] != 0) e_open |= (1 << b);
        end
    end

    function automatic string err_tag(int er, int k);
        case (er)
            1: return "R5";
            2: return "R6";
            3: return "R7";
            4: return "R8";
            default: return (k <= 1) ? "R10" : (k == 5) ? "R9" : (k >= 6 && k <= 7) ? "R8" : "R2";
        endcase
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            if (rst) begin
                check("R1", cmd_kind, 0, "kind in reset");
                check("R1", bank_open, 0, "banks in reset");
                check("R1", err_valid, 0, "err in reset");
            end else begin
                check("R2", cmd_kind, e_kind, "cmd_kind");
                check("R3", burst_bc4, e_bc4, "burst_bc4");
                check("R4", auto_pre, e_ap, "auto_pre");
                check(err_tag(e_err, e_kind), err_code, e_err, "err_code");
                check("R11", err_valid, (e_err != 0), "err_valid");
                check((e_prev_err != 0) ? "R11" : (e_ap != 0) ? "R4" : "R9", bank_open, e_open, "bank_open");
            end
        end
    end

    task automatic cmd(input logic [3:0] pins, input int b, input logic [15:0] a);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = pins;
        ba = b[2:0];
        addr = a;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cmd(4'b0111, 0, 16'h0);
    endtask

    localparam logic [3:0] P_ACT = 4'b0011, P_RD = 4'b0101, P_WR = 4'b0100,
                           P_PRE = 4'b0010, P_ZQ = 4'b0110, P_DES = 4'b1111;
    localparam logic [15:0] A_AP = 16'h0400, A_BL8 = 16'h1000;

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R8 init window then runtime windows
        cmd(P_ZQ, 0, A_AP);
        cmd(P_ACT, 1, 16'h0);
        idle(18);
        cmd(P_ACT, 1, 16'h0);
        cmd(P_ACT, 1, 16'h0);
        cmd(P_ZQ, 0, 16'h0);
        cmd(P_RD, 1, A_BL8);
        idle(4);
        cmd(P_ZQ, 0, A_AP);
        idle(9);
        cmd(P_DES, 3, 16'hFFFF);
        cmd(P_RD, 2, A_BL8);
        // R7 read burst boundaries, BL8 then chop
        cmd(P_RD, 1, A_BL8);
        cmd(P_WR, 1, A_BL8);
        idle(1);
        cmd(P_RD, 1, A_BL8);
        cmd(P_RD, 1, 16'h0);
        cmd(P_RD, 1, 16'h0);
        idle(1);
        cmd(P_RD, 1, 16'h0);
        cmd(P_WR, 1, 16'h0);
        cmd(P_WR, 1, 16'h0);
        // R4 auto precharge closing
        cmd(P_WR, 1, A_AP | A_BL8);
        idle(8);
        cmd(P_ACT, 4, 16'h0);
        cmd(P_RD, 4, A_AP);
        idle(2);
        cmd(P_RD, 4, A_AP | A_BL8);
        idle(8);
        // R3 fixed mode
        cfg_otf_en = 1'b0; cfg_fixed_bc4 = 1'b1;
        cmd(P_ACT, 5, 16'h0);
        cmd(P_RD, 5, A_BL8);
        cmd(P_RD, 5, A_BL8);
        cmd(P_RD, 5, 16'h0);
        cfg_fixed_bc4 = 1'b0;
        cmd(P_WR, 5, 16'h0);
        // R9 precharge single and all
        cmd(P_ACT, 6, 16'h0);
        cmd(P_PRE, 5, 16'h0);
        cmd(P_PRE, 7, 16'h0);
        cmd(P_PRE, 0, A_AP);
        cmd(P_RD, 6, 16'h0);
        cmd(4'b0000, 0, 16'h0);
        cmd(4'b0001, 0, 16'h0);
        idle(3);
        // random phase
        cfg_otf_en = 1'b1;
        for (int i = 0; i < 6000; i++) begin
            int r, pick;
            logic [3:0] p;
            r = $urandom_range(0, 99);
            if (i % 700 == 699) begin cfg_otf_en = ~cfg_otf_en; cfg_fixed_bc4 = $urandom_range(0, 1); end
            if (i % 1500 == 1000) cfg_ap_delay = 4'($urandom_range(0, 15));
            if (r < 25) p = 4'b0111;
            else if (r < 32) p = P_DES;
            else if (r < 50) p = P_ACT;
            else if (r < 68) p = P_RD;
            else if (r < 80) p = P_WR;
            else if (r < 92) p = P_PRE;
            else if (r < 96) p = 4'b0001;
            else p = P_ZQ;
            pick = $urandom_range(0, 3);
            cmd(p, pick, 16'($urandom));
        end
        idle(30);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles >= MAX_CYCLES);
        if (!done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, MAX_CYCLES);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule